// File: doc/BRIEF.md
# Four-Phase Handshake Bus Initiator

This block issues single read and write transactions on a small unclocked parallel bus: an 8-bit address, an 8-bit data path, a direction bit (0 = read, 1 = write), and active-low request and acknowledge lines. It runs a fully interlocked four-phase sequence. It sets up the lines, pulls request low, and waits for acknowledge to go low. It then releases request and its drive enables, and waits for acknowledge to return high. The acknowledge input comes from another timing domain and passes through a two-flop synchronizer before the controller acts on it.

On the local side, commands arrive on a valid/ready port. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle, so a caller holding `cmd_valid` is back-pressured for the whole bus transaction. Completion is reported by a one-cycle `rsp_valid` pulse that carries read data on `rsp_rdata`. The response has no ready input and cannot be stalled, so the consumer must take it in that cycle.

The bidirectional data path is split into `bus_din`, `bus_dout` and the enable `bus_doe`. Address and direction have their own enable, `bus_aoe`. While an enable is low, its outputs read as zero.

Top module: `hsb_initiator`

## Requirements
- R1: After reset, `bus_req_n` is 1, `bus_aoe`, `bus_doe` and `rsp_valid` are 0, and `cmd_ready` is 1.
- R2: A command is accepted only on an edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the cycle after acceptance until the cycle of the done pulse. A `cmd_valid` held during that window starts no further transaction.
- R3: In the cycle after acceptance, `bus_aoe` is 1 and `bus_req_n` is still 1. The address appears on `bus_addr` and the direction on `bus_cmd` (1 = write). For a write, `bus_doe` is 1 and the write data appears on `bus_dout`. The target therefore sees all of these before request falls.
- R4: `bus_req_n` stays low, with address and direction held stable, until the synchronized acknowledge is low. It rises on the third rising clock edge after `bus_ack_n` falls.
- R5: For a read, the data on `bus_din` is captured while acknowledge is seen low. It is returned on `rsp_rdata` with `rsp_valid`, and later changes on `bus_din` do not alter it.
- R6: `bus_aoe` and `bus_doe` drop to 0 in the same cycle that `bus_req_n` returns high.
- R7: `bus_doe` is 1 only during a write, and only from the setup cycle until request is released.
- R8: `rsp_valid` is a single-cycle pulse. It is asserted on the third rising edge after `bus_ack_n` returns high, and never while acknowledge is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Target address |
| cmd_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 8 | Read data of the last read |
| bus_addr | output | 8 | Bus address |
| bus_cmd | output | 1 | Bus direction, 1 = write |
| bus_aoe | output | 1 | Address/direction drive enable |
| bus_dout | output | 8 | Data driven to the bus |
| bus_doe | output | 1 | Data drive enable |
| bus_din | input | 8 | Data read from the bus |
| bus_req_n | output | 1 | Request, active low |
| bus_ack_n | input | 1 | Acknowledge, active low, asynchronous |

## Verification
The hardest situation to reach is a target that holds acknowledge low well after request has been released. During that time the block must neither report completion nor accept a new command, even while a caller keeps `cmd_valid` asserted. The bench's target model stretches the acknowledge-low phase by a random amount, and once by twenty cycles. A directed run holds `cmd_valid` with altered fields through a whole transaction, and the bench checks that only one bus request occurred. The target also scrambles `bus_din` after request rises, which shows that read data was captured at the right moment.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_REQ   = 2'd2,
    ST_REL   = 2'd3
  } hsb_state_e;
endpackage

// File: rtl/hsb_ack_sync.sv
module hsb_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_async,
  output logic ack_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= ack_n_async;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], ack_n_async};
    end
  endgenerate

  assign ack_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hsb_datapath.sv
module hsb_datapath #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_cmd,
  input  logic          cap_rd,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [DW-1:0] bus_din,
  output logic          wr_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_cmd) begin
      wr_q    <= cmd_write;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= bus_din;
  end
endmodule

// File: rtl/hsb_ctrl.sv
module hsb_ctrl
  import hsb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_write,
  input  logic wr_q,
  input  logic ack_n_s,
  output logic cmd_ready,
  output logic cap_cmd,
  output logic cap_rd,
  output logic req_n,
  output logic aoe,
  output logic doe,
  output logic rsp_valid
);
  hsb_state_e state_q, state_d;
  logic       wr_next;
  logic       drive_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_REQ;
      ST_REQ:   if (!ack_n_s) state_d = ST_REL;
      ST_REL:   if (ack_n_s)  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign cap_cmd   = cmd_ready && cmd_valid;
  assign cap_rd    = (state_q == ST_REQ) && !ack_n_s && !wr_q;
  assign wr_next   = cap_cmd ? cmd_write : wr_q;
  assign drive_d   = (state_d == ST_SETUP) || (state_d == ST_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_n     <= 1'b1;
      aoe       <= 1'b0;
      doe       <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      req_n     <= (state_d != ST_REQ);
      aoe       <= drive_d;
      doe       <= drive_d && wr_next;
      rsp_valid <= (state_q == ST_REL) && ack_n_s;
    end
  end

  // R3: request only falls after a cycle with lines already driven
  p_setup_before_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $past(aoe) && $past(req_n));
  // R4: while request is low, address/direction are driven
  p_req_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> aoe);
  // R4: request held low while acknowledge not yet seen
  p_req_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && ack_n_s) |=> !req_n);
  // R6: release of request drops both enables
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) |-> !aoe && !doe);
  // R7: data enable only for writes
  p_doe_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> wr_q && aoe);
  // R8: done is one cycle wide and follows acknowledge high
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_done_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ack_n_s));
  // R2: ready implies bus fully released
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> req_n && !aoe && !doe);
endmodule

// File: rtl/hsb_initiator.sv
module hsb_initiator #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cmd,
  output logic          bus_aoe,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  output logic          bus_req_n,
  input  logic          bus_ack_n
);
  logic          ack_n_s;
  logic          cap_cmd, cap_rd, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  hsb_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ack_n_async(bus_ack_n), .ack_n_sync(ack_n_s)
  );

  hsb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .wr_q(wr_q), .ack_n_s(ack_n_s), .cmd_ready(cmd_ready), .cap_cmd(cap_cmd),
    .cap_rd(cap_rd), .req_n(bus_req_n), .aoe(bus_aoe), .doe(bus_doe),
    .rsp_valid(rsp_valid)
  );

  hsb_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .cap_cmd(cap_cmd), .cap_rd(cap_rd),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .bus_din(bus_din), .wr_q(wr_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .rdata_q(rsp_rdata)
  );

  assign bus_addr = bus_aoe ? addr_q : '0;
  assign bus_cmd  = bus_aoe && wr_q;
  assign bus_dout = bus_doe ? wdata_q : '0;

  // R5: read data register only changes while a read is acknowledged
  p_rdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_n && !$rose(bus_req_n)) |-> $stable(rsp_rdata));
endmodule

// File: tb/hsb_initiator_tb.sv
module hsb_initiator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic       cmd_ready, rsp_valid, bus_cmd, bus_aoe, bus_doe, bus_req_n;
  logic [7:0] rsp_rdata, bus_addr, bus_dout;
  logic [7:0] bus_din = '0;
  logic       bus_ack_n = 1'b1;

  int errors = 0, checks = 0, tgt_cnt = 0, tgt_hold = 0;
  bit finished = 1'b0;
  logic [7:0] tgt_mem [256];
  logic [7:0] exp_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  hsb_initiator dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_cmd(bus_cmd), .bus_aoe(bus_aoe), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_req_n(bus_req_n),
    .bus_ack_n(bus_ack_n)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // target model: full four-phase responder with random delays
  initial begin
    logic [7:0] t_addr;
    logic       t_wr;
    int         n;
    for (int i = 0; i < 256; i++) tgt_mem[i] = init_val(i);
    forever begin
      @(negedge clk);
      if (rst_n && !bus_req_n) begin
        tgt_cnt++;
        t_addr = bus_addr;
        t_wr   = bus_cmd;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        if (t_wr) begin
          chk(bus_doe, "R7", "doe during write request", bus_doe, 1);
          tgt_mem[t_addr] = bus_dout;
        end else begin
          chk(!bus_doe, "R7", "doe during read request", bus_doe, 0);
          bus_din = tgt_mem[t_addr];
        end
        repeat ($urandom_range(0, 3)) @(negedge clk);
        chk(!bus_req_n && bus_addr == t_addr, "R4", "addr held under request",
            bus_addr, t_addr);
        bus_ack_n = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (bus_req_n == 1'b0 && n < 50);
        chk(n == 3, "R4", "request release latency", n, 3);
        chk(!bus_aoe && !bus_doe, "R6", "enables at release",
            {bus_aoe, bus_doe}, 0);
        bus_din = 8'($urandom);
        repeat ($urandom_range(0, 3) + tgt_hold) begin
          @(negedge clk);
          chk(!rsp_valid && !cmd_ready, "R8", "no done while ack low",
              {rsp_valid, cmd_ready}, 0);
        end
        bus_ack_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!rsp_valid && n < 50);
        chk(n == 3, "R8", "done latency after ack high", n, 3);
      end
    end
  end

  task automatic do_txn(input logic wr, input logic [7:0] a,
                        input logic [7:0] d, input bit hold_busy);
    int start, n;
    @(negedge clk);
    cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    start = tgt_cnt;
    @(negedge clk);
    chk(!cmd_ready, "R2", "ready low after accept", cmd_ready, 0);
    chk(bus_aoe && bus_req_n, "R3", "setup before request",
        {bus_aoe, bus_req_n}, 3);
    chk(bus_addr == a, "R3", "setup address", bus_addr, a);
    chk(bus_cmd == wr && bus_doe == wr, "R3", "setup cmd/doe",
        {bus_cmd, bus_doe}, {wr, wr});
    if (wr) chk(bus_dout == d, "R3", "setup write data", bus_dout, d);
    if (hold_busy) begin cmd_addr = ~a; cmd_write = ~wr; end
    else cmd_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 400) begin @(negedge clk); n++; end
    cmd_valid = 1'b0;
    chk(rsp_valid, "R8", "done pulse seen", rsp_valid, 1);
    chk(tgt_cnt == start + 1, "R2", "one bus request per command",
        tgt_cnt - start, 1);
    if (!wr) chk(rsp_rdata == exp_mem[a], "R5", "read data", rsp_rdata, exp_mem[a]);
    else begin
      exp_mem[a] = d;
      chk(tgt_mem[a] == d, "R3", "target got write data", tgt_mem[a], d);
    end
    @(negedge clk);
    chk(!rsp_valid, "R8", "done one cycle wide", rsp_valid, 0);
    if (!wr) chk(rsp_rdata == exp_mem[a], "R5", "read data held", rsp_rdata, exp_mem[a]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    chk(bus_req_n && !bus_aoe && !bus_doe && !rsp_valid && cmd_ready, "R1",
        "reset outputs", {bus_req_n, bus_aoe, bus_doe, rsp_valid, cmd_ready}, 5'b10001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_req_n && cmd_ready, "R1", "idle after reset", {bus_req_n, cmd_ready}, 3);
    // directed corners
    do_txn(1'b0, 8'h00, 8'h00, 1'b0);
    do_txn(1'b1, 8'hFF, 8'hA5, 1'b0);
    do_txn(1'b0, 8'hFF, 8'h00, 1'b0);
    do_txn(1'b1, 8'h00, 8'h3C, 1'b1);   // R2: valid held while busy
    do_txn(1'b0, 8'h00, 8'h00, 1'b1);
    tgt_hold = 20;                       // R8: long acknowledge hold
    do_txn(1'b0, 8'h24, 8'h00, 1'b0);
    do_txn(1'b1, 8'h31, 8'hF4, 1'b0);
    tgt_hold = 0;
    do_txn(1'b0, 8'h31, 8'h00, 1'b0);
    // constrained random mix
    for (int k = 0; k < 80; k++)
      do_txn(1'($urandom), 8'($urandom_range(0, 15)), 8'($urandom),
             1'($urandom_range(0, 3) == 0));
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule